// File: doc/BRIEF.md
# PS/2 Keyboard Byte Receiver

This block takes the clock and data lines of a PS/2 keyboard, brings both into the system clock domain, and assembles the serial frame into a byte. Once a frame completes with a correct start bit, odd parity and a stop bit, the byte is placed on a holding register and a ready flag is raised for the processor to poll. A read strobe from the processor clears that flag.

There is exactly one holding register and no queue. A byte that is not read before the next valid frame completes is replaced, so the processor must collect each byte within the gap between keyboard bytes, roughly 3 ms. Malformed frames are thrown away without touching the holding register or the flag. If the keyboard clock stops in the middle of a frame, the bit position is reset after an idle timeout, so the next frame is received from its start bit.

Top module: `kbd_byte_rx`

## Requirements
- R1: After reset, `rxReady` is 0 and `rxData` is 0x00.
- R2: A frame is eleven bits sampled on falling edges of `kbClkIn`: a 0 start bit, eight data bits with the least significant bit first, a parity bit that makes the count of ones over data and parity odd, and a 1 stop bit. A valid frame puts its data byte on `rxData` and sets `rxReady`.
- R3: `rxReady` rises on the third rising edge of `clk` after the final falling edge of `kbClkIn` is applied, and not on the second.
- R4: A frame whose start bit is 1 leaves `rxReady` and `rxData` unchanged.
- R5: A frame whose parity bit gives an even count of ones leaves `rxReady` and `rxData` unchanged.
- R6: A frame whose stop bit is 0 leaves `rxReady` and `rxData` unchanged.
- R7: A cycle with `rdStrobe` high clears `rxReady` at the next rising edge of `clk` and leaves `rxData` unchanged.
- R8: When `rdStrobe` is high in the same cycle that a valid frame completes, `rxReady` stays 1 and `rxData` takes the new byte.
- R9: A valid frame completing while `rxReady` is already 1 replaces `rxData` with the new byte and keeps `rxReady` at 1.
- R10: When `kbClkIn` shows no falling edge for `TIMEOUT_CYCLES` cycles in the middle of a frame, the partial frame is dropped and the next falling edge is taken as a start bit.
- R11: `rxData` changes only on completion of a valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| kbClkIn | input | 1 | Keyboard clock line, asynchronous |
| kbDatIn | input | 1 | Keyboard data line, asynchronous |
| rdStrobe | input | 1 | One-cycle pulse when the processor reads the data port |
| rxData | output | DATA_BITS | Last valid byte received |
| rxReady | output | 1 | High while an unread byte is held |

## Verification
The keyboard lines cross two synchronizer flops and one edge-detect flop before the frame check, so a completed byte shows on `rxReady` and `rxData` at the third system clock edge after the last falling keyboard clock; the bench samples one nanosecond after the second and third edges to pin that latency exactly. A read strobe acts at the next edge, so the bench samples at the following falling clock edge, and to force the collision case it raises the strobe in the single cycle between the second and third edges. Discarded frames and the timeout are judged after the keyboard clock has returned high and a further half bit period has passed, when any late effect would already be visible.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic shiftBit;    // take the sampled data bit into the frame register
    logic commitByte;  // last bit of a valid frame: latch byte and set ready
  } rxStrobe_t;

endpackage

// File: rtl/kbd_rx_sync.sv
module kbd_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] pipe;

  // Lines idle high, so reset to 1 to avoid a false falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], asyncIn};
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/kbd_rx_datapath.sv
module kbd_rx_datapath
  import kbd_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 kbClkIn,
  input  logic                 kbDatIn,
  input  logic                 rdStrobe,
  input  rxStrobe_t            strobes,
  output logic                 fallEdge,
  output logic                 frameOk,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady
);

  // start + data + parity are held; the stop bit is checked as it arrives
  localparam int unsigned HOLD_BITS = DATA_BITS + 2;

  logic [1:0] rawLines;
  logic [1:0] syncLines;
  logic       sClk;
  logic       sDat;
  logic       prevClk;
  logic [HOLD_BITS-1:0] frameBits;

  assign rawLines = {kbDatIn, kbClkIn};

  generate
    for (genvar g = 0; g < 2; g++) begin : gSync
      kbd_rx_sync #(.STAGES(SYNC_STAGES)) uSync (
        .clk    (clk),
        .rstN   (rstN),
        .asyncIn(rawLines[g]),
        .syncOut(syncLines[g])
      );
    end
  endgenerate

  assign sClk = syncLines[0];
  assign sDat = syncLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b1;
    else       prevClk <= sClk;
  end

  assign fallEdge = prevClk & ~sClk;

  // Bits enter at the top and move down: after all held bits,
  // bit 0 is the start bit and the top bit is parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 frameBits <= '0;
    else if (strobes.shiftBit) frameBits <= {sDat, frameBits[HOLD_BITS-1:1]};
  end

  // Start must be 0, stop (arriving now) must be 1, data+parity odd
  assign frameOk = ~frameBits[0] & sDat & (^frameBits[HOLD_BITS-1:1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rxData <= '0;
    else if (strobes.commitByte) rxData <= frameBits[DATA_BITS:1];
  end

  // A completing byte wins over a read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rxReady <= 1'b0;
    else if (strobes.commitByte) rxReady <= 1'b1;
    else if (rdStrobe)           rxReady <= 1'b0;
  end

endmodule

// File: rtl/kbd_rx_control.sv
module kbd_rx_control
  import kbd_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS      = 8,
  parameter int unsigned TIMEOUT_CYCLES = 10000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fallEdge,
  input  logic                  frameOk,
  output rxStrobe_t             strobes,
  output logic [$clog2(DATA_BITS+3)-1:0] bitCnt
);

  localparam int unsigned FRAME_LEN = DATA_BITS + 3;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam int unsigned IDLE_W    = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(FRAME_LEN - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_CYCLES - 1);

  logic [IDLE_W-1:0] idleCnt;
  logic              lastBit;

  assign lastBit = (bitCnt == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      idleCnt <= '0;
    end else if (fallEdge) begin
      idleCnt <= '0;
      bitCnt  <= lastBit ? '0 : bitCnt + 1'b1;
    end else if (bitCnt != '0) begin
      if (idleCnt == IDLE_LAST) begin
        bitCnt  <= '0;
        idleCnt <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end else begin
      idleCnt <= '0;
    end
  end

  always_comb begin
    strobes.shiftBit   = fallEdge & ~lastBit;
    strobes.commitByte = fallEdge & lastBit & frameOk;
  end

endmodule

// File: rtl/kbd_byte_rx.sv
module kbd_byte_rx
  import kbd_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS      = 8,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned TIMEOUT_CYCLES = 10000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 kbClkIn,
  input  logic                 kbDatIn,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady
);

  localparam int unsigned CNT_W = $clog2(DATA_BITS + 3);

  rxStrobe_t        strobes;
  logic             fallEdge;
  logic             frameOk;
  logic             commitByte;
  logic [CNT_W-1:0] bitCnt;

  kbd_rx_datapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .kbClkIn (kbClkIn),
    .kbDatIn (kbDatIn),
    .rdStrobe(rdStrobe),
    .strobes (strobes),
    .fallEdge(fallEdge),
    .frameOk (frameOk),
    .rxData  (rxData),
    .rxReady (rxReady)
  );

  kbd_rx_control #(
    .DATA_BITS     (DATA_BITS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uControl (
    .clk     (clk),
    .rstN    (rstN),
    .fallEdge(fallEdge),
    .frameOk (frameOk),
    .strobes (strobes),
    .bitCnt  (bitCnt)
  );

  assign commitByte = strobes.commitByte;

endmodule

// File: rtl/kbd_rx_checker.sv
module kbd_rx_checker #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdStrobe,
  input logic                 rxReady,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 commitByte,
  input logic [CNT_W-1:0]     bitCnt
);

  // R7: a read with no completing byte clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !commitByte) |=> !rxReady);

  // R8 / R9: a completing byte always leaves the flag set
  a_r8_commit_sets: assert property (@(posedge clk) disable iff (!rstN)
    commitByte |=> rxReady);

  // R11: the byte register only moves on a commit
  a_r11_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    !commitByte |=> $stable(rxData));

  // R2: the flag only rises because a frame completed
  a_r2_ready_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(commitByte));

  // R9: with no read, the flag holds
  a_r9_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rdStrobe) |=> rxReady);

  // R10: bit position never leaves the frame
  always_comb begin
    if (rstN) a_r10_cnt_bound: assert (bitCnt <= CNT_W'(DATA_BITS + 2));
  end

endmodule

bind kbd_byte_rx kbd_rx_checker #(
  .DATA_BITS(DATA_BITS),
  .CNT_W    (CNT_W)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .rdStrobe  (rdStrobe),
  .rxReady   (rxReady),
  .rxData    (rxData),
  .commitByte(commitByte),
  .bitCnt    (bitCnt)
);

// File: tb/sim_kbd_byte_rx.sv
`timescale 1ns/1ps
module sim_kbd_byte_rx;

  localparam int HALF    = 20;   // system cycles per keyboard clock half period
  localparam int TIMEOUT = 400;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       kbClkIn = 1'b1;
  logic       kbDatIn = 1'b1;
  logic       rdStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  kbd_byte_rx #(
    .DATA_BITS     (8),
    .SYNC_STAGES   (2),
    .TIMEOUT_CYCLES(TIMEOUT)
  ) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .kbClkIn (kbClkIn),
    .kbDatIn (kbDatIn),
    .rdStrobe(rdStrobe),
    .rxData  (rxData),
    .rxReady (rxReady)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bits[0] is sent first: {stop, parity, data, start}
  function automatic logic [10:0] mkFrame(input logic [7:0] d, input bit badStart,
                                          input bit badPar, input bit badStop);
    logic par;
    par = ~(^d) ^ badPar;
    return {~badStop, par, d, badStart};
  endfunction

  task automatic sendBits(input logic [10:0] bits, input int n, input bit collide,
                          output logic rdyEarly, output logic rdyLate);
    rdyEarly = 1'b0;
    rdyLate  = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      kbDatIn = bits[i];
      repeat (HALF) @(negedge clk);
      kbClkIn = 1'b0;
      if (i == 10) begin
        @(posedge clk);
        @(posedge clk);
        #1 rdyEarly = rxReady;
        if (collide) begin
          @(negedge clk) rdStrobe = 1'b1;
          @(posedge clk);
          #1 rdyLate = rxReady;
          @(negedge clk) rdStrobe = 1'b0;
        end else begin
          @(posedge clk);
          #1 rdyLate = rxReady;
        end
      end
      repeat (HALF) @(negedge clk);
      kbClkIn = 1'b1;
    end
    kbDatIn = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic readByte();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 ready after reset", {7'd0, rxReady}, 8'h00);
    check("R1 data after reset", rxData, 8'h00);
  endtask

  task automatic testValid(input logic [7:0] d);
    logic e, l;
    readByte();
    check("R7 ready cleared before frame", {7'd0, rxReady}, 8'h00);
    sendBits(mkFrame(d, 0, 0, 0), 11, 0, e, l);
    check("R3 not ready at second edge", {7'd0, e}, 8'h00);
    check("R3 ready at third edge", {7'd0, l}, 8'h01);
    check("R2 received byte", rxData, d);
  endtask

  task automatic testRead();
    logic [7:0] held;
    held = rxData;
    readByte();
    check("R7 read clears ready", {7'd0, rxReady}, 8'h00);
    check("R7 R11 read keeps data", rxData, held);
  endtask

  task automatic testBad(input string req, input bit bs, input bit bp, input bit bt);
    logic e, l;
    logic [7:0] held;
    readByte();
    held = rxData;
    sendBits(mkFrame(8'h96, bs, bp, bt), 11, 0, e, l);
    check({req, " ready stays low"}, {7'd0, rxReady}, 8'h00);
    check({req, " R11 data unchanged"}, rxData, held);
  endtask

  task automatic testOverwrite();
    logic e, l;
    readByte();
    sendBits(mkFrame(8'h11, 0, 0, 0), 11, 0, e, l);
    sendBits(mkFrame(8'h22, 0, 0, 0), 11, 0, e, l);
    check("R9 ready stays set", {7'd0, rxReady}, 8'h01);
    check("R9 newer byte kept", rxData, 8'h22);
  endtask

  task automatic testCollide();
    logic e, l;
    // ready is set from the previous scenario
    sendBits(mkFrame(8'h5A, 0, 0, 0), 11, 1, e, l);
    check("R8 ready after read collision", {7'd0, l}, 8'h01);
    check("R8 ready later", {7'd0, rxReady}, 8'h01);
    check("R8 byte after collision", rxData, 8'h5A);
    readByte();
    check("R7 cleared after collision", {7'd0, rxReady}, 8'h00);
  endtask

  task automatic testTimeout();
    logic e, l;
    readByte();
    sendBits(11'b000_0001_1110, 5, 0, e, l);
    repeat (TIMEOUT + 100) @(negedge clk);
    sendBits(mkFrame(8'hC3, 0, 0, 0), 11, 0, e, l);
    check("R10 ready after resync", {7'd0, rxReady}, 8'h01);
    check("R10 byte after resync", rxData, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testValid(8'hA5);
    testValid(8'h3C);
    testValid(8'h00);
    testValid(8'hFF);
    testValid(8'h80);
    testRead();
    testBad("R4 bad start", 1, 0, 0);
    testBad("R5 bad parity", 0, 1, 0);
    testBad("R6 bad stop", 0, 0, 1);
    testValid(8'h01);
    testOverwrite();
    testCollide();
    testTimeout();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule